// File: doc/BRIEF.md
# Fine-Grain Multithreaded Thread Selector

This block decides, on every clock edge, which of several hardware threads sharing one in-order core issues next. Threads are served in rotating order. A thread is eligible when its valid input is high and it is not waiting on an outstanding cache miss. Because the core issues in order, the choice depends only on readiness. It needs no dependency or branch state.

Each thread keeps a miss-wait flag. A miss-start pulse for that thread sets the flag, and a miss-return pulse clears it. Both pulses act in the cycle they arrive, so a thread that starts a miss is skipped at the very next edge, and a thread whose miss returns can be granted at that edge.

The grant, the thread index and the no-issue flag are registered. A pipeline stall freezes the grant and the rotation pointer. Miss tracking continues during a stall.

Top module: `fgmt_thread_select`

## Requirements
- R1: After reset, grant_o is all zeros, idle_o is 1, tid_o is 0 and the rotation pointer is at thread 0, so the first grant with all threads eligible goes to thread 0.
- R2: grant_o is one-hot or all zeros. When it is non-zero, tid_o is the binary index of its set bit. Outputs are registered: at each non-stalled edge they reflect the inputs present in the cycle before that edge.
- R3: At a non-stalled edge, the granted thread is the first eligible thread found by searching upward from the pointer, wrapping from thread N-1 to thread 0.
- R4: After a grant to thread k, the pointer becomes k+1, wrapping to 0 after N-1. When nothing is granted, the pointer keeps its value.
- R5: A miss-start pulse on thread k makes k ineligible from the edge that ends that cycle onward, until a miss-return for k arrives.
- R6: A miss-return pulse on thread k makes k eligible again from the edge that ends that cycle.
- R7: When miss-start and miss-return for the same thread arrive in the same cycle, the return wins and the thread is eligible.
- R8: When no thread is eligible at a non-stalled edge, grant_o becomes all zeros, tid_o becomes 0 and idle_o becomes 1.
- R9: While stall_i is high at an edge, grant_o, tid_o, idle_o and the pointer keep their values. Miss-start and miss-return pulses still update the wait flags.
- R10: A thread whose valid input is low is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | N_THREADS | Per-thread has-work flags |
| miss_start_i | input | N_THREADS | Per-thread cache-miss start pulses |
| miss_ret_i | input | N_THREADS | Per-thread cache-miss return pulses |
| stall_i | input | 1 | Pipeline stall; freezes selection state |
| grant_o | output | N_THREADS | One-hot issuing thread, zero when none |
| tid_o | output | TID_W | Binary index of the granted thread |
| idle_o | output | 1 | No thread issues this cycle |

## Verification
The bench targets five corner cases.

- **Wrap of the search from the last thread to thread 0.** A selector that fails to wrap would starve the low threads.
- **Same-cycle miss start and return.** A design that gave the start priority would leave a thread blocked forever.
- **Pointer hold across idle cycles.** A pointer that drifted while idle would hand the first grant after idle to the wrong thread.
- **Wait-flag updates during a stall.** A selector that dropped pulses while stalled would grant a thread that is still missing once the stall lifts.
- **Exclusion in the same cycle as the pulse.** A tracker that took effect one cycle late would issue one extra instruction from a missing thread.

A long pseudo-random run compares every cycle against a model built from the requirements.

// File: rtl/fgmt_pkg.sv
package fgmt_pkg;
  localparam int unsigned DEF_THREADS = 4;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fgmt_miss_track.sv
module fgmt_miss_track #(
  parameter int unsigned N_THREADS = fgmt_pkg::DEF_THREADS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_THREADS-1:0] miss_start_i,
  input  logic [N_THREADS-1:0] miss_ret_i,
  output logic [N_THREADS-1:0] wait_q_o,
  output logic [N_THREADS-1:0] wait_nx_o
);
  logic [N_THREADS-1:0] wait_q;

  for (genvar g = 0; g < N_THREADS; g++) begin : g_thr
    // return has priority over start
    assign wait_nx_o[g] = miss_ret_i[g] ? 1'b0 : (miss_start_i[g] | wait_q[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wait_q[g] <= 1'b0;
      else         wait_q[g] <= wait_nx_o[g];
    end

    assert_ret_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      miss_ret_i[g] |=> !wait_q[g]);
    assert_start_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (miss_start_i[g] && !miss_ret_i[g]) |=> wait_q[g]);
    assert_flag_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!miss_start_i[g] && !miss_ret_i[g]) |=> $stable(wait_q[g]));
  end

  assign wait_q_o = wait_q;
endmodule

// File: rtl/fgmt_rr_pick.sv
module fgmt_rr_pick #(
  parameter int unsigned N_THREADS = fgmt_pkg::DEF_THREADS,
  localparam int unsigned TID_W    = fgmt_pkg::idx_width(N_THREADS)
) (
  input  logic [N_THREADS-1:0] req_i,
  input  logic [TID_W-1:0]     ptr_i,
  output logic [N_THREADS-1:0] gnt_o,
  output logic [TID_W-1:0]     idx_o,
  output logic                 any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int unsigned k = 0; k < N_THREADS; k++) begin
      int unsigned j;
      j = int'(ptr_i) + k;
      if (j >= N_THREADS) j = j - N_THREADS;
      if (!any_o && req_i[j]) begin
        any_o    = 1'b1;
        gnt_o[j] = 1'b1;
        idx_o    = TID_W'(j);
      end
    end
  end
endmodule

// File: rtl/fgmt_thread_select.sv
module fgmt_thread_select #(
  parameter int unsigned N_THREADS = fgmt_pkg::DEF_THREADS,
  localparam int unsigned TID_W    = fgmt_pkg::idx_width(N_THREADS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_THREADS-1:0] valid_i,
  input  logic [N_THREADS-1:0] miss_start_i,
  input  logic [N_THREADS-1:0] miss_ret_i,
  input  logic                 stall_i,
  output logic [N_THREADS-1:0] grant_o,
  output logic [TID_W-1:0]     tid_o,
  output logic                 idle_o
);
  logic [N_THREADS-1:0] wait_q, wait_nx, elig, pick_gnt, grant_q;
  logic [TID_W-1:0]     pick_idx, ptr_q, ptr_nx, tid_q;
  logic                 pick_any, idle_q;

  fgmt_miss_track #(.N_THREADS(N_THREADS)) i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .miss_start_i(miss_start_i),
    .miss_ret_i  (miss_ret_i),
    .wait_q_o    (wait_q),
    .wait_nx_o   (wait_nx)
  );

  // same-cycle miss pulses already count
  assign elig = valid_i & ~wait_nx;

  fgmt_rr_pick #(.N_THREADS(N_THREADS)) i_pick (
    .req_i(elig),
    .ptr_i(ptr_q),
    .gnt_o(pick_gnt),
    .idx_o(pick_idx),
    .any_o(pick_any)
  );

  assign ptr_nx = (int'(pick_idx) == N_THREADS - 1) ? '0 : pick_idx + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      tid_q   <= '0;
      idle_q  <= 1'b1;
      ptr_q   <= '0;
    end else if (!stall_i) begin
      grant_q <= pick_gnt;
      tid_q   <= pick_any ? pick_idx : '0;
      idle_q  <= !pick_any;
      if (pick_any) ptr_q <= ptr_nx;
    end
  end

  assign grant_o = grant_q;
  assign tid_o   = tid_q;
  assign idle_o  = idle_q;

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  assert_tid_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> grant_o[tid_o]);
  assert_idle_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o == (grant_o == '0));
  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(grant_o) && $stable(tid_o) && $stable(idle_o) && $stable(ptr_q)));
  assert_skip_waiting_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> ((grant_o & wait_q) == '0));
  assert_valid_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> ((grant_o & ~$past(valid_i)) == '0));
  assert_ptr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !pick_any) |=> $stable(ptr_q));
endmodule

// File: tb/test_fgmt_thread_select.sv
module test_fgmt_thread_select;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] valid = '0, ms = '0, mr = '0;
  logic         stall = 1'b0;
  logic [N-1:0] grant;
  logic [1:0]   tid;
  logic         idle;

  int n_chk = 0, n_bad = 0;

  logic [N-1:0] m_wait = '0;
  int           m_ptr = 0;
  logic [N-1:0] e_gnt = '0;
  int           e_tid = 0;
  logic         e_idle = 1'b1;

  always #4 clk = ~clk;

  fgmt_thread_select #(.N_THREADS(N)) i_fgmt_thread_select (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .miss_start_i(ms),
    .miss_ret_i(mr), .stall_i(stall), .grant_o(grant), .tid_o(tid), .idle_o(idle)
  );

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] v, input logic [N-1:0] s, input logic [N-1:0] r,
                     input logic st, input string req);
    logic [N-1:0] wn, el;
    bit found;
    valid = v; ms = s; mr = r; stall = st;
    wn = (m_wait | s) & ~r;
    el = v & ~wn;
    if (!st) begin
      found = 0;
      for (int k = 0; k < N; k++) begin
        int j;
        j = (m_ptr + k) % N;
        if (!found && el[j]) begin
          found = 1; e_gnt = '0; e_gnt[j] = 1'b1; e_tid = j; m_ptr = (j + 1) % N;
        end
      end
      if (!found) begin e_gnt = '0; e_tid = 0; end
      e_idle = !found;
    end
    m_wait = wn;
    @(posedge clk); @(negedge clk);
    ms = '0; mr = '0;
    chk({req, " grant"}, int'(grant), int'(e_gnt));
    chk({req, " tid"},   int'(tid),   e_tid);
    chk({req, " idle"},  int'(idle),  int'(e_idle));
  endtask

  task automatic t_reset;
    chk("R1 reset grant", int'(grant), 0);
    chk("R1 reset idle",  int'(idle),  1);
    chk("R1 reset tid",   int'(tid),   0);
    cyc(4'hF, 0, 0, 0, "R1 first grant");
    chk("R1 first tid0", int'(tid), 0);
  endtask

  task automatic t_rotate;
    for (int i = 0; i < 7; i++) cyc(4'hF, 0, 0, 0, "R3 R4 rotate");
    chk("R3 wrap tid", int'(tid), 3);
    cyc(4'hF, 0, 0, 0, "R3 wrap");
    chk("R3 after wrap tid", int'(tid), 0);
  endtask

  task automatic t_valid_subset;
    for (int i = 0; i < 5; i++) cyc(4'b1010, 0, 0, 0, "R10 subset");
    chk("R10 no thread0", int'(grant[0]), 0);
  endtask

  task automatic t_miss;
    cyc(4'hF, 4'b0100, 0, 0, "R5 start");
    for (int i = 0; i < 6; i++) begin
      cyc(4'hF, 0, 0, 0, "R5 blocked");
      chk("R5 thread2 not granted", int'(grant[2]), 0);
    end
    cyc(4'b0100, 0, 4'b0100, 0, "R6 return");
    chk("R6 thread2 granted", int'(grant), 4);
  endtask

  task automatic t_both;
    cyc(4'b0010, 4'b0010, 0, 0, "R7 set");
    chk("R7 set idle", int'(idle), 1);
    cyc(4'b0010, 4'b0010, 4'b0010, 0, "R7 both");
    chk("R7 both granted", int'(grant), 2);
    cyc(4'b0010, 4'b0010, 4'b0010, 0, "R7 both clear");
    cyc(4'b0010, 0, 0, 0, "R7 stays clear");
    chk("R7 stays granted", int'(grant), 2);
  endtask

  task automatic t_idle;
    cyc(4'hF, 0, 0, 0, "R8 pre");
    cyc(4'hF, 4'hF, 0, 0, "R8 all miss");
    chk("R8 idle", int'(idle), 1);
    cyc(4'hF, 0, 0, 0, "R8 idle hold");
    cyc(4'hF, 0, 4'hF, 0, "R4 resume at ptr");
    cyc(4'h0, 0, 0, 0, "R8 none valid");
    chk("R8 none grant", int'(grant), 0);
  endtask

  task automatic t_stall;
    logic [N-1:0] g0;
    cyc(4'hF, 0, 0, 0, "R9 pre");
    g0 = grant;
    cyc(4'hF, 4'b1111, 0, 1, "R9 stall miss");
    chk("R9 frozen", int'(grant), int'(g0));
    cyc(4'h0, 0, 4'b0011, 1, "R9 stall ret");
    cyc(4'hF, 0, 0, 1, "R9 stall hold");
    chk("R9 still frozen", int'(grant), int'(g0));
    for (int i = 0; i < 4; i++) begin
      cyc(4'hF, 0, 0, 0, "R9 release");
      chk("R9 threads 2,3 blocked", int'(grant[3:2]), 0);
    end
    cyc(4'hF, 0, 4'b1100, 0, "R9 clean");
  endtask

  task automatic t_random;
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] v, s, r;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      v = lf[3:0] | lf[7:4];
      s = lf[11:8] & lf[6:3] & lf[15:12];
      r = lf[12:9] & ~lf[5:2];
      cyc(v, s, r, lf[14] & lf[1], "R3 random");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rotate();
    t_valid_subset();
    t_miss();
    t_both();
    t_idle();
    t_stall();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule